// File: doc/BRIEF.md
# SPI command-decoded register slave

This block is the host-facing side of a CAN-style controller. An SPI master (mode 0: the clock idles low, data is sampled on the rising edge and changes on the falling edge) talks to a 128-byte register space through a one-byte instruction set. The first byte after chip-select falls names the command. Plain reads and writes then take an address byte. Masked bit modify takes an address, a mask and a data byte. Shortcut opcodes load a transmit buffer or read a receive buffer without an address byte. Request-to-send flags transmit buffers, and soft reset returns every register to its initial value.

The block also owns a control register that requests an operating mode and a status register that reports the granted mode. It holds an interrupt flag register that the bus side sets through a per-bit input, together with an enable register that drives an active-low interrupt pin. SPI inputs are sampled by the system clock, which must run at least four times faster than the serial clock. A request-to-send command emits a one-cycle strobe per selected buffer toward the bit engine.

Top module: `spi_cmd_regfile`

## Requirements
- R1: Opcode 0x02 is followed by an address byte and then data bytes; each data byte is written to the current address, and the address then advances by one.
- R2: Opcode 0x03 is followed by an address byte; MISO returns the register at that address in the third byte and the following registers in later bytes. The 7-bit address wraps from 0x7F to 0x00.
- R3: Opcode 0x05 is followed by an address, a mask and a data byte; only bits set in the mask take the data value, and any further bytes in the frame are ignored.
- R4: Opcodes 0x40, 0x42 and 0x44 write transmit buffer n = 0, 1, 2 (based at 0x30 + 0x10·n) from offset 1 upward, with no address byte.
- R5: Opcodes 0x90 and 0x94 return receive buffer 0 (0x60) or 1 (0x70) from offset 1 upward, with no address byte. When chip-select rises after such a frame, interrupt flag bit 0 or bit 1 respectively is cleared.
- R6: Opcode 0x80 | m sets bit 3 (transmit request) of the control byte at 0x30, 0x40 or 0x50 for each set bit 0, 1 or 2 of m. In the same cycle it pulses `rts_req[n]` high for exactly one clock.
- R7: Bits 7:5 of the control register 0x0F request a mode (000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration). Status register 0x0E reports the granted mode in bits 7:5, with bits 4:0 at zero. A request of 101 to 111 leaves the reported mode unchanged, and SPI writes to 0x0E are ignored.
- R8: `int_n` is low exactly when the flag register 0x2C ANDed with the enable register 0x2B is nonzero. The bit map is: bit 0 RX0, bit 1 RX1, bits 2 to 4 TX0 to TX2, bit 5 error, bit 6 wake, bit 7 message error.
- R9: Every bit set on `flag_set` in a clock cycle is set in register 0x2C afterwards, even when an SPI write, bit modify or automatic clear targets that register in the same cycle.
- R10: MISO is 0 while chip-select is high and during opcode and address bytes. An unknown opcode changes no register and returns 0 until chip-select rises.
- R11: After the reset pin or opcode 0xC0, every register reads 0x00, except the control register, which reads 0x87 (masked with 0x17 gives 0x07), and the status register, which reads 0x80 (configuration mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | SPI chip-select, active low |
| mosi | input | 1 | Serial data from the master, MSB first |
| miso | output | 1 | Serial data to the master, MSB first |
| int_n | output | 1 | Active-low interrupt, flags ANDed with enables |
| flag_set | input | 8 | Per-bit set strobes for the interrupt flag register |
| rts_req | output | 3 | One-cycle transmit request strobes for buffers 0 to 2 |

## Verification
The flag register can be changed in a single clock both by the bus side through `flag_set` and by the serial side, through a write, a bit modify or the automatic clear at the end of a receive-buffer read. The bench provokes the collision by raising a flag strobe on the very clock in which the last rising serial-clock edge of a data byte that clears 0x2C is sampled. It then reads the register back over SPI and expects the strobed bit to be set while all other bits are cleared. A checker property demands the same thing on every cycle in which a strobe occurs.

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       int_n,
  input  logic [7:0] flag_set,
  output logic [2:0] rts_req
);
  localparam int         NREG   = 128;
  localparam logic [6:0] A_STAT = 7'h0E;
  localparam logic [6:0] A_CTRL = 7'h0F;
  localparam logic [6:0] A_IEN  = 7'h2B;
  localparam logic [6:0] A_IFL  = 7'h2C;
  localparam logic [6:0] A_TX0  = 7'h30;
  localparam logic [6:0] A_TX1  = 7'h40;
  localparam logic [6:0] A_TX2  = 7'h50;
  localparam logic [7:0] OP_WR  = 8'h02;
  localparam logic [7:0] OP_RD  = 8'h03;
  localparam logic [7:0] OP_BM  = 8'h05;
  localparam logic [7:0] OP_RST = 8'hC0;

  logic [7:0] mem [NREG];
  logic       sclk_q, cs_q;
  logic [2:0] bit_cnt, idx;
  logic [6:0] rx_sh, ptr, ld_addr;
  logic [7:0] tx_sh, op, mask, wr_data, ifl_nxt;
  logic [1:0] rx_pend;
  logic       wr_en, ld, do_rts, do_reset;

  logic [7:0] flags, ien, stat, ctrl, txc0;
  assign flags = mem[A_IFL];
  assign ien   = mem[A_IEN];
  assign stat  = mem[A_STAT];
  assign ctrl  = mem[A_CTRL];
  assign txc0  = mem[A_TX0];

  wire       rise      = !cs_n && sclk && !sclk_q;
  wire       fall      = !cs_n && !sclk && sclk_q;
  wire       byte_done = rise && bit_cnt == 3'd7;
  wire [7:0] b         = {rx_sh, mosi};
  wire       cs_rise   = cs_n && !cs_q;
  wire       is_ltx    = op == 8'h40 || op == 8'h42 || op == 8'h44;
  wire       is_rrx    = op == 8'h90 || op == 8'h94;

  assign miso  = !cs_n && tx_sh[7];
  assign int_n = ~|(flags & ien);

  function automatic logic [7:0] rst_val(input logic [6:0] a);
    return (a == A_STAT) ? 8'h80 : (a == A_CTRL) ? 8'h87 : 8'h00;
  endfunction

  always_comb begin
    wr_en = 1'b0; wr_data = b; ld = 1'b0; ld_addr = ptr;
    do_rts = 1'b0; do_reset = 1'b0;
    if (byte_done) begin
      if (idx == 3'd0) begin
        do_reset = b == OP_RST;
        do_rts   = b[7:3] == 5'b10000;
        if (b == 8'h90) begin ld = 1'b1; ld_addr = 7'h61; end
        if (b == 8'h94) begin ld = 1'b1; ld_addr = 7'h71; end
      end else if (op == OP_WR) begin
        wr_en = idx != 3'd1;
      end else if (op == OP_RD) begin
        ld = 1'b1;
        if (idx == 3'd1) ld_addr = b[6:0];
      end else if (op == OP_BM) begin
        wr_en   = idx == 3'd3;
        wr_data = (mem[ptr] & ~mask) | (b & mask);
      end else if (is_ltx) begin
        wr_en = 1'b1;
      end else if (is_rrx) begin
        ld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; cs_q <= 1'b1; bit_cnt <= '0; idx <= '0;
      rx_sh <= '0; tx_sh <= '0; op <= '0; mask <= '0; ptr <= '0;
      rx_pend <= '0; rts_req <= '0;
    end else begin
      sclk_q  <= sclk;
      cs_q    <= cs_n;
      rts_req <= do_rts ? b[2:0] : 3'b000;
      if (cs_n) begin
        bit_cnt <= '0; idx <= '0; tx_sh <= '0; rx_sh <= '0; rx_pend <= '0;
      end else begin
        if (rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          rx_sh   <= b[6:0];
        end
        if (fall && bit_cnt != 3'd0) tx_sh <= {tx_sh[6:0], 1'b0};
        if (byte_done) begin
          tx_sh <= ld ? mem[ld_addr] : 8'h00;
          idx   <= (idx == 3'd4) ? idx : idx + 3'd1;
          if (idx == 3'd0) begin
            op      <= b;
            rx_pend <= {b == 8'h94, b == 8'h90};
            case (b)
              8'h40:   ptr <= 7'h31;
              8'h42:   ptr <= 7'h41;
              8'h44:   ptr <= 7'h51;
              8'h90:   ptr <= 7'h62;
              8'h94:   ptr <= 7'h72;
              default: ;
            endcase
          end else if ((op == OP_WR || op == OP_BM) && idx == 3'd1) begin
            ptr <= b[6:0];
          end else if (op == OP_RD && idx == 3'd1) begin
            ptr <= b[6:0] + 7'd1;
          end else if (op == OP_BM && idx == 3'd2) begin
            mask <= b;
          end else if (op == OP_WR || op == OP_RD || is_ltx || is_rrx) begin
            ptr <= ptr + 7'd1;
          end
        end
      end
    end
  end

  always_comb begin
    ifl_nxt = (wr_en && ptr == A_IFL) ? wr_data : flags;
    if (cs_rise) ifl_nxt = ifl_nxt & ~{6'b0, rx_pend};
    ifl_nxt = ifl_nxt | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= rst_val(7'(i));
    end else if (do_reset) begin
      for (int i = 0; i < NREG; i++) mem[i] <= rst_val(7'(i));
      mem[A_IFL] <= flag_set;
    end else begin
      if (wr_en && ptr != A_STAT) mem[ptr] <= wr_data;
      if (do_rts && b[0]) mem[A_TX0][3] <= 1'b1;
      if (do_rts && b[1]) mem[A_TX1][3] <= 1'b1;
      if (do_rts && b[2]) mem[A_TX2][3] <= 1'b1;
      if (ctrl[7:5] <= 3'd4) mem[A_STAT] <= {ctrl[7:5], 5'b0};
      mem[A_IFL] <= ifl_nxt;
    end
  end
endmodule

// File: rtl/spi_cmd_regfile_chk.sv
module spi_cmd_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic       do_reset,
  input logic [2:0] idx,
  input logic [2:0] rts_req,
  input logic [7:0] flag_set,
  input logic [7:0] flags,
  input logic [7:0] stat,
  input logic [7:0] ctrl,
  input logic [7:0] txc0
);
  p_reset_conf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    do_reset |=> (stat == 8'h80 && ctrl == 8'h87));

  p_rts_txreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rts_req[0] |-> txc0[3]);

  p_rts_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_req != 3'b000) |=> (rts_req == 3'b000));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != 8'h00) |=> ((flags & $past(flag_set)) == $past(flag_set)));

  p_miso_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && idx == 3'd0) |-> !miso);

  p_status_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[7:5] <= 3'd4) && (stat[4:0] == 5'b0));
endmodule

bind spi_cmd_regfile spi_cmd_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .do_reset(do_reset),
  .idx(idx), .rts_req(rts_req), .flag_set(flag_set), .flags(flags),
  .stat(stat), .ctrl(ctrl), .txc0(txc0)
);

// File: tb/sim_spi_cmd_regfile.sv
module sim_spi_cmd_regfile;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [7:0] flag_set = 8'h00;
  logic miso, int_n;
  logic [2:0] rts_req;
  logic [2:0] rts_seen = 3'b000;
  int n_chk = 0, n_fail = 0;

  spi_cmd_regfile u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .int_n(int_n), .flag_set(flag_set), .rts_req(rts_req));

  always #5 clk = ~clk;
  always @(negedge clk) rts_seen <= rts_seen | rts_req;

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic ck(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r, input logic [7:0] fs = 8'h00);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      ck(2);
      r[i] = miso;
      sclk = 1'b1;
      if (i == 0) flag_set = fs;
      ck(1);
      flag_set = 8'h00;
      ck(1);
      sclk = 1'b0;
    end
  endtask

  task automatic fbeg; cs_n = 1'b0; ck(2); endtask
  task automatic fend; ck(2); cs_n = 1'b1; ck(3); endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    fbeg; xfer(8'h02, r); xfer(a, r); xfer(d, r); fend;
  endtask

  task automatic rd1(input logic [7:0] a, output logic [7:0] d, output logic [7:0] quiet);
    logic [7:0] r0, r1;
    fbeg; xfer(8'h03, r0); xfer(a, r1); xfer(8'h00, d); fend;
    quiet = r0 | r1;
  endtask

  task automatic pulse_flags(input logic [7:0] m);
    flag_set = m; ck(1); flag_set = 8'h00;
  endtask

  task automatic t_reset;
    logic [7:0] d, q;
    chk("R10 miso idle", miso, 0);
    chk("R8 int_n after reset", int_n, 1);
    rd1(8'h0F, d, q);
    chk("R11 ctrl&0x17", d & 8'h17, 8'h07);
    chk("R10 quiet cmd/addr", q, 0);
    rd1(8'h0E, d, q);
    chk("R11 status config", d, 8'h80);
  endtask

  task automatic t_burst;
    logic [7:0] r, a, b2, c;
    fbeg; xfer(8'h02, r); xfer(8'h20, r); xfer(8'hA1, r); xfer(8'hB2, r); xfer(8'hC3, r); fend;
    fbeg; xfer(8'h03, r); xfer(8'h20, r); xfer(8'h00, a); xfer(8'h00, b2); xfer(8'h00, c); fend;
    chk("R1 burst 0x20", a, 8'hA1);
    chk("R1 burst 0x21", b2, 8'hB2);
    chk("R2 seq read 0x22", c, 8'hC3);
  endtask

  task automatic t_wrap;
    logic [7:0] r, a, b2;
    fbeg; xfer(8'h02, r); xfer(8'h7F, r); xfer(8'h5A, r); xfer(8'h6B, r); fend;
    fbeg; xfer(8'h03, r); xfer(8'h7F, r); xfer(8'h00, a); xfer(8'h00, b2); fend;
    chk("R2 read 0x7F", a, 8'h5A);
    chk("R2 wrap to 0x00", b2, 8'h6B);
  endtask

  task automatic t_bitmod;
    logic [7:0] r, d, q;
    wr1(8'h24, 8'hF0);
    fbeg; xfer(8'h05, r); xfer(8'h24, r); xfer(8'h3C, r); xfer(8'hFF, r); xfer(8'h00, r); fend;
    rd1(8'h24, d, q);
    chk("R3 masked update", d, 8'hFC);
  endtask

  task automatic t_load;
    logic [7:0] r, d, q;
    fbeg; xfer(8'h42, r); xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); fend;
    rd1(8'h41, d, q); chk("R4 txbuf1 off1", d, 8'h11);
    rd1(8'h43, d, q); chk("R4 txbuf1 off3", d, 8'h33);
    rd1(8'h40, d, q); chk("R4 txbuf1 ctrl untouched", d, 8'h00);
  endtask

  task automatic t_rxread;
    logic [7:0] r, a, b2, d, q;
    fbeg; xfer(8'h02, r); xfer(8'h71, r); xfer(8'hDE, r); xfer(8'hAD, r); fend;
    pulse_flags(8'h03);
    fbeg; xfer(8'h94, r); chk("R10 quiet rx opcode", r, 0);
    xfer(8'h00, a); xfer(8'h00, b2); fend;
    chk("R5 rxbuf1 off1", a, 8'hDE);
    chk("R5 rxbuf1 off2", b2, 8'hAD);
    rd1(8'h2C, d, q);
    chk("R5 rx1 flag auto-clear", d, 8'h01);
    wr1(8'h2C, 8'h00);
  endtask

  task automatic t_rts;
    logic [7:0] r, d, q;
    rts_seen = 3'b000;
    fbeg; xfer(8'h85, r); fend;
    chk("R6 rts strobes", rts_seen, 3'b101);
    rd1(8'h30, d, q); chk("R6 txbuf0 req", d, 8'h08);
    rd1(8'h40, d, q); chk("R6 txbuf1 not req", d, 8'h00);
    rd1(8'h50, d, q); chk("R6 txbuf2 req", d, 8'h08);
  endtask

  task automatic t_mode;
    logic [7:0] d, q;
    wr1(8'h0F, 8'h40);
    rd1(8'h0E, d, q); chk("R7 loopback granted", d, 8'h40);
    wr1(8'h0F, 8'hE0);
    rd1(8'h0E, d, q); chk("R7 illegal request kept", d, 8'h40);
    wr1(8'h0E, 8'hFF);
    rd1(8'h0E, d, q); chk("R7 status not writable", d, 8'h40);
  endtask

  task automatic t_int;
    wr1(8'h2B, 8'h01);
    pulse_flags(8'h04); ck(1);
    chk("R8 disabled flag", int_n, 1);
    pulse_flags(8'h01); ck(1);
    chk("R8 enabled flag", int_n, 0);
    wr1(8'h2C, 8'h00);
    chk("R8 cleared", int_n, 1);
  endtask

  task automatic t_collide;
    logic [7:0] r, d, q;
    wr1(8'h2C, 8'h81);
    fbeg; xfer(8'h02, r); xfer(8'h2C, r); xfer(8'h00, r, 8'h20); fend;
    rd1(8'h2C, d, q);
    chk("R9 set wins over write", d, 8'h20);
    wr1(8'h2C, 8'h00);
  endtask

  task automatic t_unknown;
    logic [7:0] r, d, q;
    logic [7:0] acc = 8'h00;
    fbeg; xfer(8'h11, r); acc |= r; xfer(8'h20, r); acc |= r; xfer(8'h99, r); acc |= r; fend;
    chk("R10 unknown miso zero", acc, 0);
    rd1(8'h20, d, q);
    chk("R10 unknown no write", d, 8'hA1);
  endtask

  task automatic t_softreset;
    logic [7:0] r, d, q;
    wr1(8'h0F, 8'h00);
    fbeg; xfer(8'hC0, r); fend;
    rd1(8'h0F, d, q); chk("R11 soft reset ctrl", d, 8'h87);
    rd1(8'h0E, d, q); chk("R11 soft reset status", d, 8'h80);
    rd1(8'h20, d, q); chk("R11 soft reset data", d, 8'h00);
    rd1(8'h30, d, q); chk("R11 soft reset txreq", d, 8'h00);
  endtask

  initial begin
    ck(3); rst_n = 1'b1; ck(2);
    t_reset;
    t_burst;
    t_wrap;
    t_bitmod;
    t_load;
    t_rxread;
    t_rts;
    t_mode;
    t_int;
    t_collide;
    t_unknown;
    t_softreset;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule